// File: doc/BRIEF.md
# Line-Doubling Linear Pixel Address Counter

This block produces the video-memory read address for a frame that stores 320 by 240 pixels and is scanned out on 640 by 480 display timing. Each stored pixel is shown for two pixel clocks, and each stored row is shown on two consecutive scanlines. The memory is packed and linear: row k starts at k*320, with no power-of-two padding between rows.

The block takes the horizontal and vertical pixel counts from an external timing generator. The address advances once every two clocks while a visible pixel is scanned. It holds still through horizontal blanking and is forced to zero through vertical blanking.

A save register keeps the start address of the row being shown. At a fixed horizontal count inside blanking, the second line of each pair copies the running address into this register. At a later count on every visible line, the address is reloaded from it. The first line of a pair therefore rewinds to its own start, and the second line moves on to the next row. Counting is frozen during blanking, so the exact positions of these two points inside blanking do not change the address sequence.

Top module: `linedbl_addr_gen`

## Requirements
- R1: While `rst_n` is low, `addr` reads 0 on the cycle after the first clock edge, whatever the counts are.
- R2: During a visible pixel (hcount < H_VIS, vcount < V_VIS), `addr` equals (vcount/2)*(H_VIS/2) + hcount/2 for that pixel. The address moves up by one after each odd hcount.
- R3: From hcount = H_VIS up to and including the reload point, `addr` holds the value reached at the end of the visible part, (vcount/2)*(H_VIS/2) + H_VIS/2.
- R4: Through vertical blanking (vcount >= V_VIS), `addr` is 0 from the second blanking pixel onward. The first pixel of the first blanking line still shows (V_VIS/2)*(H_VIS/2).
- R5: On odd visible lines only, at hcount = SAVE_H, the save register takes the current address. Even lines leave it unchanged.
- R6: On every visible line, at hcount = LOAD_H, the address is reloaded from the save register. From the next pixel it reads ((vcount+1)/2)*(H_VIS/2).
- R7: Scanlines 2k and 2k+1 present identical address sequences over their visible pixels, both starting at k*(H_VIS/2).
- R8: The first visible pixel of every frame reads address 0, and the last visible pixel reads (H_VIS/2)*(V_VIS/2) - 1 (76799 with default parameters).
- R9: Any SAVE_H and LOAD_H placed in horizontal blanking, with SAVE_H < LOAD_H, give the same visible address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hcount | input | $clog2(H_TOTAL) | Horizontal pixel count from the timing generator, 0 at the first visible pixel |
| vcount | input | $clog2(V_TOTAL) | Vertical line count from the timing generator, 0 on the first visible line |
| addr | output | $clog2((H_VIS/2)*(V_VIS/2)+1) | Linear video-memory address for the pixel being scanned |

## Verification
The counts are swept pixel by pixel through several complete frames of a reduced raster, and every pixel is compared with the arithmetic address formula. Even lines, odd lines, horizontal blanking before and after the reload, and the vertical blanking lines each test a different rule: advancing, saving, reloading and clearing. A second instance with different save and reload points runs on the same counts, which separates a timing-independent design from one that depends on where those points fall. A reset asserted in the middle of a visible line checks that the address returns to zero from any state.

// File: rtl/linedbl_addr_gen.sv
module linedbl_addr_gen #(
  parameter int H_VIS   = 640,
  parameter int H_TOTAL = 800,
  parameter int SAVE_H  = 656,
  parameter int LOAD_H  = 752,
  parameter int V_VIS   = 480,
  parameter int V_TOTAL = 525,
  localparam int HC_W = $clog2(H_TOTAL),
  localparam int VC_W = $clog2(V_TOTAL),
  localparam int AW   = $clog2((H_VIS / 2) * (V_VIS / 2) + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HC_W-1:0] hcount,
  input  logic [VC_W-1:0] vcount,
  output logic [AW-1:0]   addr
);

  localparam logic [HC_W-1:0] HVIS_C = HC_W'(H_VIS);
  localparam logic [HC_W-1:0] SAVE_C = HC_W'(SAVE_H);
  localparam logic [HC_W-1:0] LOAD_C = HC_W'(LOAD_H);
  localparam logic [VC_W-1:0] VVIS_C = VC_W'(V_VIS);

  logic [AW-1:0] addr_q;
  logic [AW-1:0] save_q;

  wire line_vis = vcount < VVIS_C;
  wire pix_vis  = hcount < HVIS_C;
  wire step     = line_vis & pix_vis & hcount[0];
  wire do_save  = line_vis & (hcount == SAVE_C) & vcount[0];
  wire do_load  = line_vis & (hcount == LOAD_C);

  always_ff @(posedge clk) begin
    if (!rst_n || !line_vis) begin
      addr_q <= '0;
      save_q <= '0;
    end else begin
      if (do_load)
        addr_q <= save_q;
      else if (step)
        addr_q <= addr_q + 1'b1;
      if (do_save)
        save_q <= addr_q;
    end
  end

  assign addr = addr_q;

endmodule

module linedbl_addr_chk #(
  parameter int H_VIS  = 640,
  parameter int SAVE_H = 656,
  parameter int LOAD_H = 752,
  parameter int V_VIS  = 480,
  parameter int HC_W   = 10,
  parameter int VC_W   = 10,
  parameter int AW     = 17
) (
  input logic            clk,
  input logic            rst_n,
  input logic [HC_W-1:0] hcount,
  input logic [VC_W-1:0] vcount,
  input logic [AW-1:0]   addr,
  input logic [AW-1:0]   save_q
);

  localparam logic [HC_W-1:0] HVIS_C = HC_W'(H_VIS);
  localparam logic [HC_W-1:0] SAVE_C = HC_W'(SAVE_H);
  localparam logic [HC_W-1:0] LOAD_C = HC_W'(LOAD_H);
  localparam logic [VC_W-1:0] VVIS_C = VC_W'(V_VIS);

  // R2
  odd_pixel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount < VVIS_C && hcount < HVIS_C && hcount[0]) |=> addr == $past(addr) + 1'b1);

  // R2
  even_pixel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount < VVIS_C && hcount < HVIS_C && !hcount[0]) |=> $stable(addr));

  // R3
  hblank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount < VVIS_C && hcount >= HVIS_C && hcount != LOAD_C) |=> $stable(addr));

  // R4
  vblank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount >= VVIS_C) |=> (addr == '0 && save_q == '0));

  // R5
  odd_line_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount < VVIS_C && hcount == SAVE_C && vcount[0]) |=> save_q == $past(addr));

  // R5
  even_line_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount < VVIS_C && hcount == SAVE_C && !vcount[0]) |=> $stable(save_q));

  // R6
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vcount < VVIS_C && hcount == LOAD_C) |=> addr == $past(save_q));

endmodule

bind linedbl_addr_gen linedbl_addr_chk #(
  .H_VIS(H_VIS), .SAVE_H(SAVE_H), .LOAD_H(LOAD_H), .V_VIS(V_VIS),
  .HC_W(HC_W), .VC_W(VC_W), .AW(AW)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount),
  .addr(addr), .save_q(save_q)
);

// File: tb/linedbl_addr_gen_tb_top.sv
module linedbl_addr_gen_tb_top;

  localparam int H_VIS   = 16;
  localparam int H_TOTAL = 24;
  localparam int V_VIS   = 8;
  localparam int V_TOTAL = 11;
  localparam int SAVE_A  = 18;
  localparam int LOAD_A  = 20;
  localparam int SAVE_B  = 17;
  localparam int LOAD_B  = 23;
  localparam int HC_W    = $clog2(H_TOTAL);
  localparam int VC_W    = $clog2(V_TOTAL);
  localparam int AW      = $clog2((H_VIS / 2) * (V_VIS / 2) + 1);
  localparam int ROW     = H_VIS / 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [HC_W-1:0] hcount;
  logic [VC_W-1:0] vcount;
  logic [AW-1:0]   addr_a;
  logic [AW-1:0]   addr_b;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  linedbl_addr_gen #(
    .H_VIS(H_VIS), .H_TOTAL(H_TOTAL), .SAVE_H(SAVE_A), .LOAD_H(LOAD_A),
    .V_VIS(V_VIS), .V_TOTAL(V_TOTAL)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount), .addr(addr_a)
  );

  linedbl_addr_gen #(
    .H_VIS(H_VIS), .H_TOTAL(H_TOTAL), .SAVE_H(SAVE_B), .LOAD_H(LOAD_B),
    .V_VIS(V_VIS), .V_TOTAL(V_TOTAL)
  ) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .hcount(hcount), .vcount(vcount), .addr(addr_b)
  );

  function automatic int expect_addr(int h, int v, int load_h);
    if (v >= V_VIS) return (v == V_VIS && h == 0) ? (V_VIS / 2) * ROW : 0;
    if (h < H_VIS)  return (v / 2) * ROW + h / 2;
    if (h <= load_h) return (v / 2) * ROW + ROW;
    return ((v + 1) / 2) * ROW;
  endfunction

  function automatic string tag_for(int h, int v);
    if (v >= V_VIS) return "R4";
    if (h == 0 && v == 0) return "R8";
    if (h == H_VIS - 1 && v == V_VIS - 1) return "R8";
    if (h == 0 && v[0] == 1'b0) return "R5";
    if (h < H_VIS) return v[0] ? "R7" : "R2";
    if (h <= LOAD_A) return "R3";
    return "R6";
  endfunction

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s h=%0d v=%0d actual=%0d expected=%0d", tag, hcount, vcount, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    hcount = HC_W'(H_TOTAL - 1);
    vcount = VC_W'(V_TOTAL - 1);
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(addr_a), 0);
    check("R1", int'(addr_b), 0);
    rst_n = 1'b1;
    for (int f = 0; f < 3; f++) begin
      for (int v = 0; v < V_TOTAL; v++) begin
        for (int h = 0; h < H_TOTAL; h++) begin
          @(negedge clk);
          hcount = HC_W'(h);
          vcount = VC_W'(v);
          #1;
          check(tag_for(h, v), int'(addr_a), expect_addr(h, v, LOAD_A));
          // R9: alternative save/reload points
          check("R9", int'(addr_b), expect_addr(h, v, LOAD_B));
        end
      end
    end
    // R1: reset in the middle of a visible line
    for (int h = 0; h < 9; h++) begin
      @(negedge clk);
      hcount = HC_W'(h);
      vcount = VC_W'(5);
    end
    rst_n = 1'b0;
    @(negedge clk);
    #1;
    check("R1", int'(addr_a), 0);
    check("R1", int'(addr_b), 0);
    finish_run();
  end

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

endmodule